// File: doc/BRIEF.md
# Two-wire EEPROM slave controller

This block is the slave side of a two-wire serial bus (I2C-style) in front of a 512-byte store. It oversamples SCL and SDA with the system clock, finds start and stop conditions, and decodes the first byte of each transfer as a device address. That address byte holds a fixed type code, two bits that must equal the levels on two strap inputs, one high array-address bit, and the direction bit. Because of the strap match, four copies can share one bus.

A write carries a word address byte and one data byte. The block acknowledges both and stores the byte only when the master then sends a stop. The store is followed by a simulated internal write cycle of a set number of clocks. During that cycle the block flags itself busy and ignores the bus completely. A read returns bytes starting at the internal address counter, stepping the counter after each byte, for as long as the master keeps acknowledging.

SDA is modelled as open drain. The block only ever pulls the line low, through `sda_oe_o`.

Top module: `eeprom_2w_slave`

## Requirements
- R1: After reset, `sda_oe_o` and `busy_o` are 0, and the block waits for a start condition.
- R2: Bits are taken MSB first, with SDA sampled on the rising edge of SCL. In the first byte after a start, bits 7..4 must be 1010, bit 3 must equal `strap_i[1]` and bit 2 must equal `strap_i[0]`, bit 1 is the high array-address bit, and bit 0 selects read (1) or write (0).
- R3: The array index is 9 bits wide. It is formed as {address-byte bit 1, 8-bit word address}.
- R4: After a matching address byte, after the word address byte and after the data byte, the block pulls SDA low for the whole ninth SCL clock.
- R5: If the type code or either strap bit differs, the block gives no acknowledge. It then ignores all bus activity until the next start.
- R6: A stop that follows an acknowledged data byte writes that byte to the array at the 9-bit index. The address counter then becomes index+1 modulo 512.
- R7: `busy_o` rises on the clock after that stop is detected and stays high for exactly WRITE_CYCLES clocks.
- R8: While `busy_o` is high, the block never drives SDA. Start conditions, stop conditions and address bytes have no effect during this time.
- R9: A read returns the byte at the address counter, MSB first, and increments the counter modulo 512 after each byte. The block goes on sending bytes while the master acknowledges. It releases SDA and returns to idle on a not-acknowledge.
- R10: `sda_oe_o` changes only while SCL is low.
- R11: A start condition anywhere in a transfer restarts the address phase, and a stop before the write is complete returns the block to idle. In both cases any write that has not yet received its closing stop is discarded, with no array change and no busy period.
- R12: The acknowledged word address loads the address counter at once, even if the write is later abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus) |
| strap_i | input | 2 | Board straps compared with address bits 3..2 |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| busy_o | output | 1 | High during the internal write cycle |

## Verification
Byte writes are tried at indices with the high address bit both clear and set. A read that starts at index 511 shows the 9-bit split and the wrap to 0 in a single pass. Address bytes with a wrong strap pair, with a wrong type code, and with correct bits but no preceding start show that acknowledges depend on both fields and on the start. Two abandoned writes separate the discard rules from the counter rule: one ends in a repeated start after the data acknowledge, the other in a stop halfway through the data byte. Both must leave the old byte in place and create no busy period, yet both must move the counter. An address byte sent during the busy window shows the bus is ignored.

// File: rtl/eeprom_2w_pkg.sv
package eeprom_2w_pkg;

   localparam logic [3:0] DEV_TYPE = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_WSTOP,
      ST_TX,
      ST_MACK,
      ST_RLOAD,
      ST_BUSY
   } ctl_state_t;

   typedef enum logic [1:0] {
      PH_DEV,
      PH_WORD,
      PH_DATA
   } rx_phase_t;

endpackage

// File: rtl/e2w_line_sampler.sv
module e2w_line_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_level,
   output logic sda_level,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   initial assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");

   logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
   logic                   scl_prev, sda_prev;

   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= scl_i;
               sda_pipe <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
               sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_pipe[SYNC_STAGES-1];
         sda_prev <= sda_pipe[SYNC_STAGES-1];
      end
   end

   assign scl_level = scl_pipe[SYNC_STAGES-1];
   assign sda_level = sda_pipe[SYNC_STAGES-1];
   assign scl_rise  = !scl_prev && scl_level;
   assign scl_fall  = scl_prev && !scl_level;
   assign start_det = scl_prev && scl_level && sda_prev && !sda_level;
   assign stop_det  = scl_prev && scl_level && !sda_prev && sda_level;

endmodule

// File: rtl/e2w_byte_array.sv
module e2w_byte_array #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   initial assert (DEPTH * DATA_W <= 8192) else $error("array too large for register storage");

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

   AST_WRITE_ADDR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> !$isunknown({waddr, wdata})); // R6

endmodule

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave
   import eeprom_2w_pkg::*;
#(
   parameter int WORD_W       = 8,
   parameter int DATA_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int WRITE_CYCLES = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [1:0] strap_i,
   output logic       sda_oe_o,
   output logic       busy_o
);

   localparam int ADDR_W = WORD_W + 1;
   localparam int BIT_W  = $clog2(DATA_W);
   localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);
   localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(WRITE_CYCLES - 1);

   initial assert (DATA_W == 8) else $error("address byte layout needs DATA_W == 8");
   initial assert (WORD_W == DATA_W) else $error("word address must fill one bus byte");
   initial assert (WRITE_CYCLES >= 1) else $error("WRITE_CYCLES must be at least 1");

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   e2w_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_level (scl_s),
      .sda_level (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   ctl_state_t        state;
   rx_phase_t         phase;
   logic [BIT_W-1:0]  bit_cnt;
   logic              byte_done;
   logic [DATA_W-1:0] shreg, txbyte, wr_data, rd_byte;
   logic [ADDR_W-1:0] cur_addr;
   logic              addr_hi, rd_mode, oe;
   logic [CNT_W-1:0]  wait_cnt;
   logic              mem_we, dev_match;

   assign dev_match = (shreg[7:4] == DEV_TYPE) && (shreg[3:2] == strap_i);
   assign mem_we    = (state == ST_WSTOP) && stop_det;

   e2w_byte_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .waddr (cur_addr),
      .wdata (wr_data),
      .raddr (cur_addr),
      .rdata (rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         phase     <= PH_DEV;
         bit_cnt   <= '0;
         byte_done <= 1'b0;
         shreg     <= '0;
         txbyte    <= '0;
         wr_data   <= '0;
         cur_addr  <= '0;
         addr_hi   <= 1'b0;
         rd_mode   <= 1'b0;
         oe        <= 1'b0;
         wait_cnt  <= '0;
      end else if (state == ST_BUSY) begin
         if (wait_cnt == LAST_WAIT) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
         end else begin
            wait_cnt <= wait_cnt + CNT_W'(1);
         end
      end else if (start_det) begin
         state     <= ST_RX;
         phase     <= PH_DEV;
         bit_cnt   <= '0;
         byte_done <= 1'b0;
         oe        <= 1'b0;
      end else if (stop_det) begin
         oe        <= 1'b0;
         byte_done <= 1'b0;
         bit_cnt   <= '0;
         if (state == ST_WSTOP) begin
            state    <= ST_BUSY;
            cur_addr <= cur_addr + ADDR_W'(1);
            wait_cnt <= '0;
         end else begin
            state <= ST_IDLE;
         end
      end else begin
         case (state)
            ST_RX: begin
               if (scl_rise) begin
                  shreg <= {shreg[DATA_W-2:0], sda_s};
                  if (bit_cnt == LAST_BIT) begin
                     bit_cnt   <= '0;
                     byte_done <= 1'b1;
                  end else begin
                     bit_cnt <= bit_cnt + BIT_W'(1);
                  end
               end else if (scl_fall && byte_done) begin
                  byte_done <= 1'b0;
                  case (phase)
                     PH_DEV: begin
                        if (dev_match) begin
                           oe      <= 1'b1;
                           state   <= ST_ACK;
                           rd_mode <= shreg[0];
                           addr_hi <= shreg[1];
                        end else begin
                           state <= ST_IDLE;
                        end
                     end
                     PH_WORD: begin
                        oe       <= 1'b1;
                        state    <= ST_ACK;
                        cur_addr <= {addr_hi, shreg[WORD_W-1:0]};
                     end
                     default: begin
                        oe      <= 1'b1;
                        state   <= ST_ACK;
                        wr_data <= shreg;
                     end
                  endcase
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  oe <= 1'b0;
                  case (phase)
                     PH_DEV: begin
                        if (rd_mode) begin
                           txbyte  <= rd_byte;
                           oe      <= !rd_byte[DATA_W-1];
                           state   <= ST_TX;
                           bit_cnt <= '0;
                        end else begin
                           phase <= PH_WORD;
                           state <= ST_RX;
                        end
                     end
                     PH_WORD: begin
                        phase <= PH_DATA;
                        state <= ST_RX;
                     end
                     default: state <= ST_WSTOP;
                  endcase
               end
            end
            ST_TX: begin
               if (scl_rise) begin
                  if (bit_cnt == LAST_BIT) begin
                     bit_cnt   <= '0;
                     byte_done <= 1'b1;
                     cur_addr  <= cur_addr + ADDR_W'(1);
                  end else begin
                     bit_cnt <= bit_cnt + BIT_W'(1);
                  end
               end else if (scl_fall) begin
                  if (byte_done) begin
                     byte_done <= 1'b0;
                     oe        <= 1'b0;
                     state     <= ST_MACK;
                  end else begin
                     oe <= !txbyte[LAST_BIT - bit_cnt];
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) state <= sda_s ? ST_IDLE : ST_RLOAD;
            end
            ST_RLOAD: begin
               if (scl_fall) begin
                  txbyte  <= rd_byte;
                  oe      <= !rd_byte[DATA_W-1];
                  state   <= ST_TX;
                  bit_cnt <= '0;
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe_o = oe;
   assign busy_o   = (state == ST_BUSY);

   AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !sda_oe_o); // R8

   AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACK && phase == PH_DEV) |-> (shreg[7:4] == DEV_TYPE && shreg[3:2] == strap_i)); // R5

   AST_OE_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe_o)); // R10

   AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(stop_det)); // R7

endmodule

// File: tb/eeprom_2w_slave_test.sv
module eeprom_2w_slave_test;

   localparam int WCYC = 600;
   localparam int H    = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [1:0] strap = 2'b10;
   logic       sda_oe, busy;
   logic       sda_line;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   always #4 clk = !clk;

   assign sda_line = sda_m & !sda_oe;

   eeprom_2w_slave #(.WRITE_CYCLES(WCYC)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_line),
      .strap_i  (strap),
      .sda_oe_o (sda_oe),
      .busy_o   (busy)
   );

   task automatic check(input string tag, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   // per-clock reference: released line stays put while SCL is high (R10),
   // and every busy window lasts exactly WCYC clocks (R7)
   logic prev_scl = 1'b1, prev_oe = 1'b0;
   int   busy_len = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_scl && scl_m) check("R10 oe steady while SCL high", int'(sda_oe), int'(prev_oe));
         if (busy) busy_len++;
         else if (busy_len != 0) begin
            check("R7 busy length", busy_len, WCYC);
            busy_len = 0;
         end
      end
      prev_scl = scl_m;
      prev_oe  = sda_oe;
   end

   task automatic half();
      repeat (H) @(negedge clk);
   endtask

   task automatic start_cond();
      sda_m = 1'b1; half();
      scl_m = 1'b1; half();
      sda_m = 1'b0; half();
      scl_m = 1'b0; repeat (4) @(negedge clk);
   endtask

   task automatic stop_cond();
      sda_m = 1'b0; half();
      scl_m = 1'b1; half();
      sda_m = 1'b1; half();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; half();
         scl_m = 1'b1; half();
         scl_m = 1'b0; repeat (4) @(negedge clk);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      sda_m = 1'b1; half();
      scl_m = 1'b1;
      repeat (H/2) @(negedge clk);
      ack = !sda_line;
      repeat (H/2) @(negedge clk);
      scl_m = 1'b0; half();
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         half();
         scl_m = 1'b1;
         repeat (H/2) @(negedge clk);
         b[i] = sda_line;
         repeat (H/2) @(negedge clk);
         scl_m = 1'b0;
      end
      repeat (4) @(negedge clk);
      sda_m = !mack; half();
      scl_m = 1'b1; half();
      scl_m = 1'b0; repeat (4) @(negedge clk);
      sda_m = 1'b1; half();
   endtask

   function automatic logic [7:0] dev_byte(input logic [1:0] s, input logic a8, input logic rw);
      return {4'b1010, s, a8, rw};
   endfunction

   task automatic wait_idle();
      while (busy) @(negedge clk);
      repeat (10) @(negedge clk);
   endtask

   task automatic do_write(input logic [8:0] idx, input logic [7:0] d, input bit probe);
      logic ack;
      start_cond();
      send_byte(dev_byte(strap, idx[8], 1'b0), ack); check("R4 ack address", int'(ack), 1);
      send_byte(idx[7:0], ack); check("R4 ack word", int'(ack), 1);
      send_byte(d, ack); check("R4 ack data", int'(ack), 1);
      stop_cond();
      repeat (10) @(negedge clk);
      check("R7 busy after stop", int'(busy), 1);
      if (probe) begin
         start_cond();
         send_byte(dev_byte(strap, 1'b0, 1'b0), ack);
         check("R8 no ack while busy", int'(ack), 0);
         check("R8 still busy", int'(busy), 1);
         stop_cond();
      end
      wait_idle();
   endtask

   initial begin
      logic ack;
      logic [7:0] b;
      repeat (10) @(negedge clk);
      check("R1 reset oe", int'(sda_oe), 0);
      check("R1 reset busy", int'(busy), 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);

      do_write(9'h1FE, 8'h11, 1);
      do_write(9'h1FF, 8'h3C, 0);   // R3 high index bit set
      do_write(9'h000, 8'h77, 0);
      do_write(9'h1FE, 8'h11, 0);   // R6 counter -> 0x1FF

      start_cond();
      send_byte(dev_byte(strap, 1'b0, 1'b1), ack); check("R2 read ack", int'(ack), 1);
      recv_byte(1'b1, b); check("R9 R3 read at 0x1FF", int'(b), 'h3C);
      recv_byte(1'b0, b); check("R9 wrap to 0x000", int'(b), 'h77);
      check("R9 released after nack", int'(sda_oe), 0);
      stop_cond();

      start_cond();
      send_byte(dev_byte(2'b01, 1'b0, 1'b0), ack); check("R5 strap mismatch", int'(ack), 0);
      send_byte(dev_byte(strap, 1'b0, 1'b0), ack); check("R5 no start, no ack", int'(ack), 0);
      stop_cond();
      start_cond();
      send_byte({4'b1011, strap, 2'b00}, ack); check("R5 type mismatch", int'(ack), 0);
      stop_cond();

      do_write(9'h010, 8'h5A, 0);
      do_write(9'h00F, 8'h12, 0);

      // write ended by a repeated start instead of a stop
      start_cond();
      send_byte(dev_byte(strap, 1'b0, 1'b0), ack); check("R4 ack address", int'(ack), 1);
      send_byte(8'h10, ack); check("R4 ack word", int'(ack), 1);
      send_byte(8'hEE, ack); check("R4 ack data", int'(ack), 1);
      start_cond();
      send_byte(dev_byte(strap, 1'b0, 1'b1), ack); check("R11 restart ack", int'(ack), 1);
      recv_byte(1'b0, b); check("R11 R12 old byte kept", int'(b), 'h5A);
      stop_cond();
      repeat (10) @(negedge clk);
      check("R11 no busy after restart", int'(busy), 0);

      // stop in the middle of the data byte
      start_cond();
      send_byte(dev_byte(strap, 1'b0, 1'b0), ack); check("R4 ack address", int'(ack), 1);
      send_byte(8'h10, ack); check("R4 ack word", int'(ack), 1);
      send_bits(8'hEE, 4);
      stop_cond();
      repeat (10) @(negedge clk);
      check("R11 no busy after partial byte", int'(busy), 0);
      start_cond();
      send_byte(dev_byte(strap, 1'b0, 1'b1), ack); check("R2 read ack", int'(ack), 1);
      recv_byte(1'b0, b); check("R12 counter reloaded, R11 byte kept", int'(b), 'h5A);
      stop_cond();

      repeat (20) @(negedge clk);
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired");
      summary();
   end

endmodule